// File: doc/BRIEF.md
# First-Fault Gather Load Sequencer

This block carries out one predicated vector gather load with first-fault behaviour. A start handshake delivers a per-lane predicate, a 64-bit scalar base, one 64-bit offset per lane, the incoming first-fault mask, and three mode bits. The mode bits select whether offsets are taken as 32-bit values, whether such values are sign- or zero-extended, and whether they are scaled by four. The block then visits lanes in ascending order from lane 0. Each active lane issues one word read on a memory request/response port. Each response carries a data word and a fault flag.

Only the first active lane may raise a precise fault, which the block reports together with the address that faulted. A fault on any later active lane is suppressed instead. The block clears every mask bit from that lane upward and issues no further reads. When the walk ends, the block presents the assembled destination vector and the updated mask, and pulses `done`. Lanes that are known-unsafe read as zero.

Both memory channels are valid/ready. `mem_req_addr` holds steady while `mem_req_valid` waits for `mem_req_ready`. Only one read is ever outstanding, and `mem_rsp_ready` is high only while that read is awaited. The start channel is accepted only while `start_ready` is high, which is exactly when the block is idle. The result, mask and fault outputs stay constant from the `done` pulse until the next accepted start.

Top module: `ffg_seq`

## Requirements
- R1: Each read address is base plus the lane offset. In 32-bit offset mode (`mode_off32`=1), only bits 31:0 of the offset are used: they are sign-extended when `mode_sext`=1 and zero-extended otherwise. When `mode_scale`=1, the extended offset is shifted left by 2 before the add.
- R2: A lane whose predicate bit is 0 issues no read and never faults, and its result element is zero.
- R3: Reads go out in ascending lane order. At most one read is outstanding at a time. A pending request keeps its address stable until it is accepted.
- R4: If the first active lane's response faults, `done` rises with `fault_valid`=1 and `fault_addr` equal to that lane's address. In that case `ffr_out` equals the incoming mask and `result` is all zero.
- R5: A fault on a later active lane leaves `fault_valid`=0, clears `ffr_out` bits from that lane through the top lane, and no further read is issued.
- R6: A lane's element is zero when any `ffr_out` bit from lane 0 up to and including that lane is 0.
- R7: Lane i occupies `result[i*ELEM_W +: ELEM_W]`. A loaded word is zero-extended into its element, so bits above 31 are zero when ELEM_W is 64.
- R8: With no active lane, no read is made, `done` pulses, and `ffr_out` equals the incoming mask.
- R9: A start is taken only while `start_ready`=1, and `start_ready` is 0 from acceptance until after `done`. `done` is a single-cycle pulse, and the outputs hold their values until the next start.
- R10: `ffr_out` never has a 1 where the incoming mask had a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Block idle, start accepted |
| start_pred | input | LANES | Per-lane predicate |
| start_base | input | 64 | Scalar base address |
| start_offs | input | LANES*64 | Per-lane offsets, lane i at bits i*64 +: 64 |
| start_ffr | input | LANES | Incoming first-fault mask |
| mode_off32 | input | 1 | Use 32-bit offsets |
| mode_sext | input | 1 | Sign-extend 32-bit offsets |
| mode_scale | input | 1 | Multiply offsets by 4 |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_ready | output | 1 | Block awaits response |
| mem_rsp_data | input | 32 | Loaded word |
| mem_rsp_fault | input | 1 | Access faulted |
| done | output | 1 | One-cycle completion pulse |
| result | output | LANES*ELEM_W | Destination vector |
| ffr_out | output | LANES | Updated first-fault mask |
| fault_valid | output | 1 | Precise fault on first active lane |
| fault_addr | output | 64 | Address of the precise fault |

## Verification
The hardest case to reach is a suppressed fault on a chosen later lane, while the incoming mask already has a cleared bit and the memory side applies back-pressure. In that case the stop point, the mask clearing and the zeroing of unknown lanes all interact. The bench's memory model faults every address at or above a programmable threshold. With offsets that rise with the lane index, the threshold picks exactly the first faulting lane. Request-ready and response latency are randomised every cycle.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK,
    ST_REQ,
    ST_RSP,
    ST_DONE
  } ffg_state_e;
endpackage

// File: rtl/ffg_addr_gen.sv
module ffg_addr_gen (
  input  logic [63:0] base,
  input  logic [63:0] offset,
  input  logic        off32,
  input  logic        sext,
  input  logic        scale,
  output logic [63:0] addr
);
  logic [63:0] ext_off;
  logic [63:0] scaled;

  always_comb begin
    if (off32)
      ext_off = sext ? {{32{offset[31]}}, offset[31:0]} : {32'b0, offset[31:0]};
    else
      ext_off = offset;
    scaled = scale ? {ext_off[61:0], 2'b00} : ext_off;
    addr   = base + scaled;
  end
endmodule

// File: rtl/ffg_lane_pick.sv
module ffg_lane_pick #(
  parameter int LANES = 8,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CW = IW + 1
) (
  input  logic [LANES-1:0] pred,
  input  logic [CW-1:0]    cursor,
  output logic             found,
  output logic [IW-1:0]    lane
);
  logic [LANES-1:0] cand;

  for (genvar g = 0; g < LANES; g++) begin : g_cand
    assign cand[g] = pred[g] && (CW'(g) >= cursor);
  end

  always_comb begin
    found = 1'b0;
    lane  = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        lane  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ffg_prefix_keep.sv
module ffg_prefix_keep #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] ffr,
  output logic [LANES-1:0] keep
);
  assign keep[0] = ffr[0];
  for (genvar g = 1; g < LANES; g++) begin : g_chain
    assign keep[g] = keep[g-1] & ffr[g];
  end
endmodule

// File: rtl/ffg_seq.sv
module ffg_seq #(
  parameter int LANES  = 8,
  parameter int ELEM_W = 32,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CW    = IW + 1,
  localparam int RES_W = LANES * ELEM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_valid,
  output logic               start_ready,
  input  logic [LANES-1:0]   start_pred,
  input  logic [63:0]        start_base,
  input  logic [LANES*64-1:0] start_offs,
  input  logic [LANES-1:0]   start_ffr,
  input  logic               mode_off32,
  input  logic               mode_sext,
  input  logic               mode_scale,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [63:0]        mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [31:0]        mem_rsp_data,
  input  logic               mem_rsp_fault,
  output logic               done,
  output logic [RES_W-1:0]   result,
  output logic [LANES-1:0]   ffr_out,
  output logic               fault_valid,
  output logic [63:0]        fault_addr
);
  import ffg_pkg::*;

  ffg_state_e          state;
  logic [LANES-1:0]    pred_q;
  logic [63:0]         base_q;
  logic [LANES*64-1:0] offs_q;
  logic                off32_q, sext_q, scale_q;
  logic [LANES-1:0]    ffr_in_q;
  logic [LANES-1:0]    ffr_q;
  logic [RES_W-1:0]    raw_q;
  logic [CW-1:0]       cursor_q;
  logic [IW-1:0]       lane_q;
  logic                first_q;
  logic                fault_q;
  logic [63:0]         fault_addr_q;

  logic                pick_found;
  logic [IW-1:0]       pick_lane;
  logic [63:0]         lane_addr;
  logic [LANES-1:0]    keep;
  logic [ELEM_W-1:0]   elem_word;
  logic [LANES-1:0]    low_mask;

  ffg_lane_pick #(.LANES(LANES)) u_pick (
    .pred   (pred_q),
    .cursor (cursor_q),
    .found  (pick_found),
    .lane   (pick_lane)
  );

  ffg_addr_gen u_addr (
    .base   (base_q),
    .offset (offs_q[lane_q*64 +: 64]),
    .off32  (off32_q),
    .sext   (sext_q),
    .scale  (scale_q),
    .addr   (lane_addr)
  );

  ffg_prefix_keep #(.LANES(LANES)) u_keep (
    .ffr  (ffr_q),
    .keep (keep)
  );

  if (ELEM_W > 32) begin : g_wide
    assign elem_word = {{(ELEM_W-32){1'b0}}, mem_rsp_data};
  end else begin : g_narrow
    assign elem_word = mem_rsp_data[ELEM_W-1:0];
  end

  assign low_mask = ~({LANES{1'b1}} << lane_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      pred_q       <= '0;
      base_q       <= '0;
      offs_q       <= '0;
      off32_q      <= 1'b0;
      sext_q       <= 1'b0;
      scale_q      <= 1'b0;
      ffr_in_q     <= '0;
      ffr_q        <= '0;
      raw_q        <= '0;
      cursor_q     <= '0;
      lane_q       <= '0;
      first_q      <= 1'b0;
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_valid) begin
            pred_q       <= start_pred;
            base_q       <= start_base;
            offs_q       <= start_offs;
            off32_q      <= mode_off32;
            sext_q       <= mode_sext;
            scale_q      <= mode_scale;
            ffr_in_q     <= start_ffr;
            ffr_q        <= start_ffr;
            raw_q        <= '0;
            cursor_q     <= '0;
            first_q      <= 1'b1;
            fault_q      <= 1'b0;
            fault_addr_q <= '0;
            state        <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (pick_found) begin
            lane_q <= pick_lane;
            state  <= ST_REQ;
          end else begin
            state  <= ST_DONE;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_RSP;
        end
        ST_RSP: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_fault) begin
              if (first_q) begin
                fault_q      <= 1'b1;
                fault_addr_q <= lane_addr;
                ffr_q        <= ffr_in_q;
              end else begin
                ffr_q <= ffr_q & low_mask;
              end
              state <= ST_DONE;
            end else begin
              raw_q[lane_q*ELEM_W +: ELEM_W] <= elem_word;
              first_q  <= 1'b0;
              cursor_q <= {1'b0, lane_q} + CW'(1);
              state    <= ST_WALK;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign start_ready   = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = lane_addr;
  assign mem_rsp_ready = (state == ST_RSP);
  assign done          = (state == ST_DONE);
  assign ffr_out       = ffr_q;
  assign fault_valid   = fault_q;
  assign fault_addr    = fault_addr_q;

  for (genvar g = 0; g < LANES; g++) begin : g_res
    assign result[g*ELEM_W +: ELEM_W] = keep[g] ? raw_q[g*ELEM_W +: ELEM_W] : '0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !mem_req_valid && !mem_rsp_ready); // R9
  AST_FAULT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_valid |-> ffr_out == ffr_in_q); // R4
  AST_MASK_ANDDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ffr_out & ~ffr_in_q) == '0); // R10
endmodule

// File: tb/ffg_seq_test.sv
module ffg_seq_test;
  localparam int LANES = 8;
  localparam int EW    = 32;
  localparam int RW    = LANES * EW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic               start_valid = 1'b0;
  logic               start_ready;
  logic [LANES-1:0]   start_pred = '0;
  logic [63:0]        start_base = '0;
  logic [LANES*64-1:0] start_offs = '0;
  logic [LANES-1:0]   start_ffr = '0;
  logic               mode_off32 = 1'b0, mode_sext = 1'b0, mode_scale = 1'b0;
  logic               mem_req_valid, mem_req_ready = 1'b0;
  logic [63:0]        mem_req_addr;
  logic               mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [31:0]        mem_rsp_data = '0;
  logic               mem_rsp_fault = 1'b0;
  logic               done;
  logic [RW-1:0]      result;
  logic [LANES-1:0]   ffr_out;
  logic               fault_valid;
  logic [63:0]        fault_addr;

  ffg_seq #(.LANES(LANES), .ELEM_W(EW)) uut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] fthr = '1;
  logic [63:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdata(input logic [63:0] a);
    return a[31:0] ^ 32'hC3C3_0F0F;
  endfunction

  function automatic logic [63:0] eaddr(input logic [63:0] b, input logic [63:0] o,
                                        input bit o32, input bit sx, input bit sc);
    logic [63:0] e;
    if (o32) e = sx ? {{32{o[31]}}, o[31:0]} : {32'b0, o[31:0]};
    else     e = o;
    if (sc) e = e << 2;
    return b + e;
  endfunction

  // memory responder with random back-pressure and latency
  logic        prev_req_fire = 1'b0, prev_rsp_fire = 1'b0, pending = 1'b0;
  logic [63:0] pend_addr = '0;
  int          delay = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_req_fire) begin
        if (exp_q.size() == 0) chk(1'b0, "R2/R5 unexpected read", RW'(mem_req_addr), '0);
        else begin
          chk(mem_req_addr == exp_q[0], "R1/R3 read address", RW'(mem_req_addr), RW'(exp_q[0]));
          void'(exp_q.pop_front());
        end
        pending   = 1'b1;
        pend_addr = mem_req_addr;
        delay     = $urandom_range(0, 2);
      end
      if (prev_rsp_fire) mem_rsp_valid = 1'b0;
      if (pending && mem_req_valid) chk(1'b0, "R3 second outstanding read", 1, 0);
      mem_req_ready = ($urandom_range(0, 3) != 0);
      if (pending && !mem_rsp_valid) begin
        if (delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mdata(pend_addr);
          mem_rsp_fault = (pend_addr >= fthr);
          pending       = 1'b0;
        end else delay--;
      end
      prev_req_fire = mem_req_valid & mem_req_ready;
      prev_rsp_fire = mem_rsp_valid & mem_rsp_ready;
    end
  end

  task automatic run_op(input string tag, input logic [LANES-1:0] pred, input logic [63:0] base,
                        input logic [LANES*64-1:0] offs, input logic [LANES-1:0] ffr,
                        input bit o32, input bit sx, input bit sc);
    logic [RW-1:0]    eres = '0;
    logic [LANES-1:0] effr = ffr;
    bit               efault = 0, first = 1, ok = 1;
    logic [63:0]      efaddr = '0;
    int               cyc = 0;
    exp_q.delete();
    for (int l = 0; l < LANES; l++) begin
      if (pred[l]) begin
        logic [63:0] a = eaddr(base, offs[l*64 +: 64], o32, sx, sc);
        bit f = (a >= fthr);
        exp_q.push_back(a);
        if (first && f) begin efault = 1; efaddr = a; break; end
        if (f) begin
          for (int k = l; k < LANES; k++) effr[k] = 1'b0;
          break;
        end
        first = 0;
        eres[l*EW +: EW] = mdata(a);
      end
    end
    for (int l = 0; l < LANES; l++) begin
      ok = ok & effr[l];
      if (!ok || efault) eres[l*EW +: EW] = '0;
    end
    @(negedge clk);
    start_pred = pred; start_base = base; start_offs = offs; start_ffr = ffr;
    mode_off32 = o32; mode_sext = sx; mode_scale = sc;
    chk(start_ready == 1'b1, "R9 idle before start", RW'(start_ready), 1);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk(start_ready == 1'b0, "R9 busy after accept", RW'(start_ready), 0);
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    if (!done) begin chk(1'b0, {tag, " watchdog"}, 0, 1); return; end
    chk(result == eres, {tag, " result"}, result, eres);
    chk(ffr_out == effr, "R5/R6 ffr_out", RW'(ffr_out), RW'(effr));
    chk((ffr_out & ~ffr) == '0, "R10 mask only cleared", RW'(ffr_out), RW'(ffr));
    chk(fault_valid == efault, "R4 fault_valid", RW'(fault_valid), RW'(efault));
    if (efault) chk(fault_addr == efaddr, "R4 fault_addr", RW'(fault_addr), RW'(efaddr));
    chk(exp_q.size() == 0, "R3/R8 all expected reads issued", RW'(exp_q.size()), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single pulse", RW'(done), 0);
    chk(result == eres && ffr_out == effr, "R9 outputs held", result, eres);
  endtask

  function automatic logic [LANES*64-1:0] mk_offs(input logic [63:0] b0, input logic [63:0] step);
    logic [LANES*64-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*64 +: 64] = b0 + step * 64'(l);
    return v;
  endfunction

  initial begin
    int wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_ready && !done && !mem_req_valid, "R9 reset state",
            RW'({start_ready, done, mem_req_valid}), RW'(3'b100));
        // R1 R7: zero-extended 32-bit offsets, scaled; upper offset bits ignored
        run_op("R7", 8'hFF, 64'h1000, mk_offs(64'hABCD_0000_0000_0000, 1), 8'hFF, 1, 0, 1);
        // R1: sign-extended negative offsets, no scaling
        run_op("R1", 8'hFF, 64'h10_0000, mk_offs(64'h0000_DEAD_FFFF_FFF0, 1), 8'hFF, 1, 1, 0);
        // R1: full 64-bit offsets, scaled
        run_op("R1", 8'hFF, 64'h40, mk_offs(64'h1_0000_0000, 16), 8'hFF, 0, 0, 1);
        // R2: sparse predicate
        run_op("R2", 8'b1010_0110, 64'h3000, mk_offs(0, 8), 8'hFF, 1, 0, 0);
        // R8: no active lane
        run_op("R8", 8'h00, 64'h3000, mk_offs(0, 8), 8'hF3, 1, 0, 0);
        // R4: first active lane (lane 4) faults
        fthr = 64'h5000 + 64'd16;
        run_op("R4", 8'hF0, 64'h5000, mk_offs(0, 1), 8'hBF, 1, 0, 1);
        // R5: suppressed fault at lane 5
        fthr = 64'h2000 + 64'd20;
        run_op("R5", 8'hFF, 64'h2000, mk_offs(0, 1), 8'hFF, 1, 0, 1);
        fthr = '1;
        // R6: incoming mask bit 2 clear
        run_op("R6", 8'hFF, 64'h6000, mk_offs(0, 1), 8'b1111_1011, 1, 0, 1);
        // R5 R6: sparse lanes, mask bit 6 clear, suppressed fault at lane 3
        fthr = 64'h7000 + 64'd12;
        run_op("R6", 8'b0110_1001, 64'h7000, mk_offs(0, 1), 8'b1011_1111, 1, 0, 1);
        fthr = '1;
        // R3: back-to-back run after faults
        run_op("R3", 8'h7E, 64'h8000, mk_offs(64'h20, 4), 8'hFF, 1, 0, 1);
      end
      begin
        while (wd < 100000) begin @(posedge clk); wd++; end
        chk(1'b0, "R9 global watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule